// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that makes a small on-chip register file look like a serial EEPROM to a bus master. The bus pins are first cleaned up. SCL and SDA each pass through a two-stage synchronizer and a glitch filter. The filtered levels are then turned into START, STOP and clock-edge events. A protocol engine decodes the selection byte and the two word-address bytes, and then either takes in one data byte or shifts out stored bytes MSB first. The target only ever pulls SDA low. The bus resolves the line as open-drain.

A write is held in a staging register and reaches the array only when the STOP that closes the transfer arrives. That STOP also starts a timed write cycle. For the whole cycle the target treats the bus as absent. A write-protect input vetoes the update. Reads come in two forms. A current-address read uses the internal pointer as it stands. A random read first sets the pointer with a dummy write, then issues a repeated START.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the target does not drive SDA (`sda_oe` = 0), and every array location reads as 0x00.
- R2: The first byte after any START is the selection byte. Bits [7:4] must be 4'b1010, bits [3:1] must equal `strap_i[2:0]`, and bit 0 selects read (1) or write (0). On a match the target pulls SDA low for the ninth clock. In any other cycle of a received byte it leaves SDA released.
- R3: On a mismatched selection byte the target does not acknowledge. It then ignores all bytes until the next START.
- R4: A write sends the word address as two bytes, high byte first. The target acknowledges both bytes and the following data byte. Address bits at and above ADDR_W are ignored. A fourth byte in the same transfer is not acknowledged.
- R5: The data byte reaches the array only if a STOP ends the transfer. A repeated START in its place discards the write.
- R6: The STOP that commits a write starts a busy period of TWR_CYC clock cycles. During that period the target acknowledges nothing, START conditions included.
- R7: While `wp_i` is high at the STOP, the array is not changed and no busy period follows. The bytes of the transfer are still acknowledged.
- R8: A read shifts out the byte at the pointer MSB first and then advances the pointer. A master ACK continues with the next location. After a master NACK the target releases SDA until the next START or STOP.
- R9: A random read is a dummy write of the two address bytes followed by a repeated START and a read selection. It returns the byte at that address.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN clock cycles after synchronization does not change the filtered level and does not register as a bus event.
- R11: After a committed write the pointer holds the written address plus one. A current-address read therefore returns the following location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Board-strapped selection bits; tie to 0 when unused |
| wp_i | input | 1 | 1 blocks every array update |

## Verification
On every cycle, assertions check three things. SDA is never driven while the engine is idle or busy. Outside a read it is only driven in the acknowledge slot. The busy state can only be entered from a STOP that closes a completed, unprotected write. A further assertion confirms that the filtered line levels only take values that the synchronizer held beforehand. Only the bench scenarios can show the data-dependent behaviour: the selection sweep over every strap and select value, MSB-first order, pointer advance, the discarded write on a repeated START, write protection, and the deafness during the write cycle.

// File: rtl/eep_pkg.sv
// Shared definitions for the serial EEPROM target.
// Assumes: the word address is no wider than 16 bits.
package eep_pkg;

    // Fixed device-type nibble expected in the selection byte
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Protocol engine states
    typedef enum logic [3:0] {
        ST_IDLE,   // waiting for START
        ST_DEV,    // receiving selection byte
        ST_AHI,    // receiving high word-address byte
        ST_ALO,    // receiving low word-address byte
        ST_WDATA,  // receiving data byte
        ST_WDONE,  // data staged, waiting for STOP
        ST_RD,     // shifting read data out
        ST_HOLD,   // silent until START or STOP
        ST_BUSY    // timed write cycle, bus ignored
    } eep_state_e;

endpackage

// File: rtl/eep_line_filter.sv
// Synchronizes and deglitches a set of bus lines, then flags edges.
// Does: two flip-flop synchronizer, then a level that follows the
// synchronized input only after FILT_LEN consecutive differing cycles.
// Assumes: lines idle high; FILT_LEN >= 2.
module eep_line_filter #(
    parameter int LINES    = 2,
    parameter int FILT_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);
    localparam int CNT_W = $clog2(FILT_LEN);

    logic [LINES-1:0] sync1, sync2, prev;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [CNT_W-1:0] cnt;

        // Two-stage synchronizer into the clock domain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync1[i] <= 1'b1;
                sync2[i] <= 1'b1;
            end else begin
                sync1[i] <= raw_i[i];
                sync2[i] <= sync1[i];
            end
        end

        // Follow the synchronized input only once it has been stable long enough
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_o[i] <= 1'b1;
                cnt      <= '0;
            end else if (sync2[i] == lvl_o[i]) begin
                cnt <= '0;
            end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
                lvl_o[i] <= sync2[i];
                cnt      <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end

        // Remember last filtered level for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) prev[i] <= 1'b1;
            else        prev[i] <= lvl_o[i];
        end

        assign rise_o[i] =  lvl_o[i] & ~prev[i];
        assign fall_o[i] = ~lvl_o[i] &  prev[i];

        AST_FILT_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(lvl_o[i]) |-> ($past(sync2[i]) == lvl_o[i])); // R10
    end

endmodule

// File: rtl/eep_regfile.sv
// Byte-wide register file standing in for the storage array.
// Does: one synchronous write port and one combinational read port.
// Assumes: cleared to zero by reset.
module eep_regfile #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise store one byte per write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/eep_wr_timer.sv
// Counts out the internal write cycle.
// Does: loads TWR_CYC on a start pulse and reports busy until it reaches zero.
// Assumes: TWR_CYC >= 1.
module eep_wr_timer #(
    parameter int TWR_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(TWR_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Load on start, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (go_i)       cnt <= CNT_W'(TWR_CYC);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> (cnt < $past(cnt)) || $past(go_i)); // R6

endmodule

// File: rtl/i2c_eeprom_target.sv
// I2C target fronting a byte register file with EEPROM-like behaviour.
// Does: selection against straps, two-byte word address, single-byte
// write committed at STOP followed by a timed deaf period, current and
// random reads with pointer auto-increment, whole-array write protect.
// Assumes: ADDR_W <= 16; bus timing slow compared with clk (each SCL
// phase much longer than FILT_LEN + 3 clocks).
module i2c_eeprom_target
    import eep_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int FILT_LEN = 4,
    parameter int TWR_CYC  = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);
    localparam int LN_SCL = 1;
    localparam int LN_SDA = 0;

    logic [1:0] lvl, rise, fall;
    logic       start_det, stop_det, scl_rise, scl_fall;

    eep_state_e        st;
    logic [3:0]        bit_cnt;
    logic [7:0]        sr, addr_hi, wdat, rd_sr, rdata;
    logic [ADDR_W-1:0] ptr;
    logic              dev_match, ack_now, commit, tmr_busy;

    eep_line_filter #(.LINES(2), .FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    eep_regfile #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
        .clk(clk), .rst_n(rst_n), .we_i(commit), .waddr_i(ptr),
        .wdata_i(wdat), .raddr_i(ptr), .rdata_o(rdata)
    );

    eep_wr_timer #(.TWR_CYC(TWR_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .go_i(commit), .busy_o(tmr_busy)
    );

    // Bus events from filtered levels
    assign start_det = lvl[LN_SCL] & fall[LN_SDA];
    assign stop_det  = lvl[LN_SCL] & rise[LN_SDA];
    assign scl_rise  = rise[LN_SCL];
    assign scl_fall  = fall[LN_SCL];

    // Selection match and acknowledge decision for the byte just received
    assign dev_match = (sr[7:4] == DEV_TYPE) && (sr[3:1] == strap_i);
    always_comb begin
        if (st == ST_DEV) ack_now = dev_match;
        else              ack_now = st inside {ST_AHI, ST_ALO, ST_WDATA};
    end

    // A STOP after a complete, unprotected write commits it
    assign commit = stop_det && (st == ST_WDONE) && !wp_i;

    // Protocol engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            sr      <= '0;
            addr_hi <= '0;
            wdat    <= '0;
            rd_sr   <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
        end else if (st == ST_BUSY) begin
            if (!tmr_busy) st <= ST_IDLE;
        end else if (start_det) begin
            st      <= ST_DEV;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            sda_oe <= 1'b0;
            if (commit) begin
                st  <= ST_BUSY;
                ptr <= ptr + 1'b1;
            end else begin
                st <= ST_IDLE;
            end
        end else if (st == ST_RD) begin
            if (scl_rise) begin
                if (bit_cnt < 4'd8) begin
                    bit_cnt <= bit_cnt + 4'd1;
                end else if (bit_cnt == 4'd8) begin
                    if (lvl[LN_SDA]) begin
                        st      <= ST_HOLD;
                        bit_cnt <= '0;
                    end else begin
                        bit_cnt <= 4'd9;
                    end
                end
            end else if (scl_fall) begin
                if (bit_cnt == 4'd9) begin
                    rd_sr   <= rdata;
                    sda_oe  <= ~rdata[7];
                    ptr     <= ptr + 1'b1;
                    bit_cnt <= '0;
                end else if (bit_cnt == 4'd8) begin
                    sda_oe <= 1'b0;
                end else begin
                    rd_sr  <= {rd_sr[6:0], 1'b0};
                    sda_oe <= ~rd_sr[6];
                end
            end
        end else if (st != ST_IDLE) begin
            if (scl_rise && bit_cnt < 4'd8) begin
                sr      <= {sr[6:0], lvl[LN_SDA]};
                bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
                bit_cnt <= 4'd9;
                sda_oe  <= ack_now;
                if (st == ST_DEV && !dev_match) st <= ST_IDLE;
            end else if (scl_fall && bit_cnt == 4'd9) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                case (st)
                    ST_DEV: begin
                        if (sr[0]) begin
                            st     <= ST_RD;
                            rd_sr  <= rdata;
                            sda_oe <= ~rdata[7];
                            ptr    <= ptr + 1'b1;
                        end else begin
                            st <= ST_AHI;
                        end
                    end
                    ST_AHI: begin
                        addr_hi <= sr;
                        st      <= ST_ALO;
                    end
                    ST_ALO: begin
                        ptr <= ADDR_W'({addr_hi, sr});
                        st  <= ST_WDATA;
                    end
                    ST_WDATA: begin
                        wdat <= sr;
                        st   <= ST_WDONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe); // R3

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY) |-> !sda_oe); // R6

    AST_ACK_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && st != ST_RD) |-> (bit_cnt == 4'd9)); // R2

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && $past(st) != ST_BUSY) |-> $past(stop_det && !wp_i && st == ST_WDONE)); // R5

    AST_WP_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_i && stop_det && st == ST_WDONE) |=> (st == ST_IDLE)); // R7

endmodule

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;
    localparam int H   = 20;
    localparam int Q   = 10;
    localparam int TWR = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic [2:0] strap = 3'd0;
    logic       sda_oe;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_oe;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    i2c_eeprom_target #(.ADDR_W(8), .FILT_LEN(4), .TWR_CYC(TWR)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .wp_i(wp)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i_start;
        wt(Q); sda_m = 1'b1; wt(Q); scl = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl = 1'b0;
    endtask

    task automatic i_stop;
        wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic wr_bit(input logic b);
        wt(Q); sda_m = b; wt(Q); scl = 1'b1; wt(H); scl = 1'b0;
    endtask

    task automatic rd_bit(output logic b);
        wt(Q); sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); b = sda_line; wt(Q); scl = 1'b0;
    endtask

    // acked = 1 when the target pulled SDA low in the ninth clock
    task automatic wr_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) wr_bit(d[i]);
        rd_bit(b);
        acked = ~b;
    endtask

    task automatic rd_byte(output logic [7:0] d, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rd_bit(b);
            d[i] = b;
        end
        wr_bit(nack);
    endtask

    function automatic logic [7:0] sel_byte(input logic [2:0] s, input logic rd);
        return {4'b1010, s, rd};
    endfunction

    task automatic byte_write(input logic [15:0] a, input logic [7:0] d);
        logic k0, k1, k2, k3;
        i_start;
        wr_byte(sel_byte(strap, 1'b0), k0);
        wr_byte(a[15:8], k1);
        wr_byte(a[7:0], k2);
        wr_byte(d, k3);
        i_stop;
        chk("R4 write acks", {4'h0, k0, k1, k2, k3}, 8'h0F);
        wt(TWR + 200);
    endtask

    task automatic rand_read(input logic [15:0] a, output logic [7:0] d);
        logic k0, k1, k2, k3;
        i_start;
        wr_byte(sel_byte(strap, 1'b0), k0);
        wr_byte(a[15:8], k1);
        wr_byte(a[7:0], k2);
        i_start;
        wr_byte(sel_byte(strap, 1'b1), k3);
        rd_byte(d, 1'b1);
        i_stop;
        chk("R9 random read acks", {4'h0, k0, k1, k2, k3}, 8'h0F);
    endtask

    initial begin
        logic       ak, b;
        logic [7:0] d;

        wt(5);
        rst_n = 1'b1;
        wt(2);
        chk("R1 SDA released after reset", {7'd0, sda_oe}, 8'h00);

        // R2/R3: every strap value against every select value
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            for (int sel = 0; sel < 8; sel++) begin
                i_start;
                wr_byte(sel_byte(3'(sel), 1'b0), ak);
                i_stop;
                if (sel == s) chk("R2 matching select acked", {7'd0, ak}, 8'h01);
                else          chk("R3 mismatching select not acked", {7'd0, ak}, 8'h00);
            end
        end
        strap = 3'd5;

        // R2: wrong device-type nibble
        i_start;
        wr_byte({4'b1011, 3'd5, 1'b0}, ak);
        i_stop;
        chk("R2 wrong type nibble not acked", {7'd0, ak}, 8'h00);

        // R3: after a mismatch, a matching byte without START is ignored
        i_start;
        wr_byte(sel_byte(3'd2, 1'b0), ak);
        wr_byte(sel_byte(3'd5, 1'b0), ak);
        i_stop;
        chk("R3 ignored until next START", {7'd0, ak}, 8'h00);

        // R1: fresh array reads zero
        rand_read(16'h0023, d);
        chk("R1 array cleared", d, 8'h00);

        // R4: byte write with high-order address bits beyond ADDR_W, extra byte refused
        i_start;
        wr_byte(sel_byte(strap, 1'b0), ak); chk("R4 select ack", {7'd0, ak}, 8'h01);
        wr_byte(8'h01, ak);                 chk("R4 high address ack", {7'd0, ak}, 8'h01);
        wr_byte(8'h23, ak);                 chk("R4 low address ack", {7'd0, ak}, 8'h01);
        wr_byte(8'hA7, ak);                 chk("R4 data ack", {7'd0, ak}, 8'h01);
        wr_byte(8'h55, ak);                 chk("R4 fourth byte not acked", {7'd0, ak}, 8'h00);
        i_stop;

        // R6: deaf during the write cycle
        i_start;
        wr_byte(sel_byte(strap, 1'b0), ak);
        i_stop;
        chk("R6 no ack during write cycle", {7'd0, ak}, 8'h00);
        wt(TWR + 200);

        // R9/R4/R8: random read of location 0x23 (high byte ignored), MSB first
        rand_read(16'h0023, d);
        chk("R9 random read data", d, 8'hA7);

        // R11: current-address read after a write returns the next location
        byte_write(16'h0061, 8'h4D);
        byte_write(16'h0060, 8'h1E);
        i_start;
        wr_byte(sel_byte(strap, 1'b1), ak);
        rd_byte(d, 1'b1);
        i_stop;
        chk("R11 current read select ack", {7'd0, ak}, 8'h01);
        chk("R11 current read data", d, 8'h4D);

        // R8: sequential read with master ACK, then NACK releases SDA
        i_start;
        wr_byte(sel_byte(strap, 1'b0), ak);
        wr_byte(8'h00, ak);
        wr_byte(8'h60, ak);
        i_start;
        wr_byte(sel_byte(strap, 1'b1), ak);
        rd_byte(d, 1'b0);
        chk("R8 first byte MSB first", d, 8'h1E);
        rd_byte(d, 1'b1);
        chk("R8 pointer advanced", d, 8'h4D);
        rd_bit(b);
        chk("R8 released after NACK", {7'd0, b}, 8'h01);
        i_stop;

        // R7: protected write acked, no cycle, array unchanged
        wp = 1'b1;
        i_start;
        wr_byte(sel_byte(strap, 1'b0), ak);
        wr_byte(8'h00, ak);
        wr_byte(8'h23, ak);
        wr_byte(8'h00, ak);
        chk("R7 data acked while protected", {7'd0, ak}, 8'h01);
        i_stop;
        i_start;
        wr_byte(sel_byte(strap, 1'b0), ak);
        i_stop;
        chk("R7 no write cycle while protected", {7'd0, ak}, 8'h01);
        wp = 1'b0;
        rand_read(16'h0023, d);
        chk("R7 location unchanged", d, 8'hA7);

        // R5: repeated START instead of STOP discards the write
        i_start;
        wr_byte(sel_byte(strap, 1'b0), ak);
        wr_byte(8'h00, ak);
        wr_byte(8'h70, ak);
        wr_byte(8'h99, ak);
        i_start;
        wr_byte(sel_byte(strap, 1'b0), ak);
        i_stop;
        chk("R5 no write cycle after abandoned write", {7'd0, ak}, 8'h01);
        rand_read(16'h0070, d);
        chk("R5 abandoned data not stored", d, 8'h00);

        // R10: a two-cycle SCL glitch must not add a bit
        i_start;
        wt(Q); scl = 1'b1; wt(2); scl = 1'b0;
        wr_byte(sel_byte(strap, 1'b0), ak);
        i_stop;
        chk("R10 short SCL pulse filtered", {7'd0, ak}, 8'h01);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule